// File: doc/BRIEF.md
# Queue-Port Host Messaging Unit

This block is the device-side register window through which a host hands work to an I/O processor and collects the results. The host sees a small set of 32-bit registers on a simple memory-mapped slave bus. Two of them are queue ports. A read of the request port hands the host a free request slot taken from a free list that the local processor seeds. A write to that port posts a request. A read of the completion port collects a finished request, and a write to it gives a device-memory request slot back to the free list.

Besides the queues, the window holds two command registers that the host writes and two response registers that the local processor writes, a host-to-device doorbell, and a status/mask pair for each direction. Writing the response register with the value of a pending command tells the host that the command is finished. A posted word with bit 31 set names a 32-byte-aligned request in host memory. The block decodes such a word for the local processor into a full host bus address.

Top module: `qpmu_top`

## Requirements
- R1: After reset all three queues are empty, all messages, doorbell bits, status bits and mask bits are zero, both interrupt outputs are low and `h_rdata` is zero.
- R2: A host read at offset 0x40 returns the oldest entry of the free list, in the order the local side pushed it with `l_free_push`, and removes that entry. Read data appears on `h_rdata` one clock after the read cycle.
- R3: A host read at 0x40 with an empty free list, or at 0x44 with an empty completion queue, returns 0xFFFFFFFF and leaves that queue unchanged.
- R4: A host write at 0x40 appends the word to the post queue, which the local side drains in order with `l_post_pop` while `l_post_valid` is high. Each post sets inbound status bit 3. When bit 31 of the head word is 1, `l_post_host` is 1 and `l_post_addr` is bits 30:0 shifted left by 5. Otherwise `l_post_host` is 0 and `l_post_addr` is the word zero-extended.
- R5: `l_cpl_push` appends `l_cpl_data` to the completion queue and sets outbound status bit 3. Host reads at 0x44 return the entries in push order.
- R6: A host write at 0x44 appends the word to the free list. During that cycle `l_free_rdy` is low and a local free push is not taken.
- R7: Host writes at 0x10 and 0x14 load command words 0 and 1 (output on `l_cmd0`/`l_cmd1`) and set inbound status bits 0 and 1. `l_rsp_we[0]`/`l_rsp_we[1]` load response words read at 0x18/0x1C and set outbound status bits 0 and 1.
- R8: Status bits are write-one-to-clear. Outbound status (read at 0x30) is cleared by host writes at 0x30, and inbound status (read at 0x24, output on `l_istat`) is cleared by `l_in_clr`. Zero bits leave a bit alone, and a set in the same cycle wins over a clear.
- R9: `h_irq` is the OR of outbound status bits whose mask bit (offset 0x34) is 0. `l_irq` is the same for inbound status with the mask at 0x28. A mask bit of 1 blocks its source.
- R10: A host write at 0x20 ORs the word into the doorbell (`l_db`, readable at 0x20). `l_db_clr` clears bits, and a host set wins over a clear. Inbound status bit 2 is set in every cycle in which the doorbell is non-zero.
- R11: Host writes at 0x18, 0x1C, 0x24 and at unmapped offsets change nothing, and reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | 1 write, 0 read |
| h_addr | input | ADDR_W | Byte offset in the window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after a read |
| h_irq | output | 1 | Interrupt toward the host |
| l_free_push | input | 1 | Local push onto the free list |
| l_free_data | input | 32 | Free request offset |
| l_free_rdy | output | 1 | Local free push will be taken |
| l_post_pop | input | 1 | Local pop of the post queue |
| l_post_valid | output | 1 | Post queue not empty |
| l_post_data | output | 32 | Head of the post queue |
| l_post_host | output | 1 | Head names a host-memory request |
| l_post_addr | output | 36 | Decoded request address |
| l_cpl_push | input | 1 | Local push of a completion |
| l_cpl_data | input | 32 | Completion word (posted value or context) |
| l_cpl_full | output | 1 | Completion queue full |
| l_cmd0 | output | 32 | Command word 0 |
| l_cmd1 | output | 32 | Command word 1 |
| l_rsp_we | input | 2 | Response word write enables |
| l_rsp_data | input | 32 | Response word data |
| l_db | output | 32 | Doorbell bits |
| l_db_clr | input | 32 | Doorbell bits to clear |
| l_istat | output | 4 | Inbound status |
| l_in_clr | input | 4 | Inbound status bits to clear |
| l_irq | output | 1 | Interrupt toward the local processor |

## Verification
The assertions assume that the local processor never pushes a completion while `l_cpl_full` is high and never pops the post queue while `l_post_valid` is low. They also assume that `h_sel` is a one-cycle strobe with the address and data stable. The directed stimulus drives every strobe for exactly one cycle, away from the clock edge. It keeps each queue well inside its depth and pops or pushes on the local side only when the matching flag permits it.

// File: rtl/qpmu_pkg.sv
package qpmu_pkg;
   localparam int DW        = 32;
   localparam int ALIGN_SH  = 5;
   localparam int HADDR_W   = DW - 1 + ALIGN_SH;
   localparam int NSRC      = 4;
   localparam logic [DW-1:0] EMPTY_MARK = '1;

   // byte offsets seen by the host driver
   localparam int OFF_CMD0  = 'h10;
   localparam int OFF_CMD1  = 'h14;
   localparam int OFF_RSP0  = 'h18;
   localparam int OFF_RSP1  = 'h1C;
   localparam int OFF_BELL  = 'h20;
   localparam int OFF_ISTAT = 'h24;
   localparam int OFF_IMASK = 'h28;
   localparam int OFF_OSTAT = 'h30;
   localparam int OFF_OMASK = 'h34;
   localparam int OFF_QREQ  = 'h40;
   localparam int OFF_QCPL  = 'h44;

   // status bit positions (shared by both directions)
   localparam int SRC_MSG0  = 0;
   localparam int SRC_MSG1  = 1;
   localparam int SRC_BELL  = 2;
   localparam int SRC_QUEUE = 3;
endpackage

// File: rtl/qpmu_fifo.sv
module qpmu_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("qpmu_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_n, rp_n;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   if (POW2) begin : g_wrap_free
      assign wp_n = wp + AW'(1);
      assign rp_n = rp + AW'(1);
   end else begin : g_wrap_cmp
      assign wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      assign rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_n;
         if (do_pop)  rp <= rp_n;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   assert_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));
   assert_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && !do_push && $countones(cnt) == 1 && cnt == CW'(1)) |=> empty);
endmodule

// File: rtl/qpmu_stat.sv
module qpmu_stat #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] mask,
   output logic [N-1:0] status,
   output logic         irq
);
   if (N < 1) begin : g_bad_n
      $error("qpmu_stat: N must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | set;
   end

   assign irq = |(status & ~mask);

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((status & $past(set)) == $past(set)));
   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~set) != '0) |=> ((status & $past(clr & ~set)) == '0));
endmodule

// File: rtl/qpmu_top.sv
module qpmu_top
   import qpmu_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int FREE_DEPTH    = 8,
   parameter int POST_DEPTH    = 8,
   parameter int CPL_DEPTH     = 8,
   parameter bit CPL_IRQ_LEVEL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                h_sel,
   input  logic                h_wr,
   input  logic [ADDR_W-1:0]   h_addr,
   input  logic [DW-1:0]       h_wdata,
   output logic [DW-1:0]       h_rdata,
   output logic                h_irq,
   input  logic                l_free_push,
   input  logic [DW-1:0]       l_free_data,
   output logic                l_free_rdy,
   input  logic                l_post_pop,
   output logic                l_post_valid,
   output logic [DW-1:0]       l_post_data,
   output logic                l_post_host,
   output logic [HADDR_W-1:0]  l_post_addr,
   input  logic                l_cpl_push,
   input  logic [DW-1:0]       l_cpl_data,
   output logic                l_cpl_full,
   output logic [DW-1:0]       l_cmd0,
   output logic [DW-1:0]       l_cmd1,
   input  logic [1:0]          l_rsp_we,
   input  logic [DW-1:0]       l_rsp_data,
   output logic [DW-1:0]       l_db,
   input  logic [DW-1:0]       l_db_clr,
   output logic [NSRC-1:0]     l_istat,
   input  logic [NSRC-1:0]     l_in_clr,
   output logic                l_irq
);
   if (ADDR_W < 7) begin : g_bad_addr
      $error("qpmu_top: ADDR_W too small for the register window");
   end

   logic wr, rd;
   logic hit_cmd0, hit_cmd1, hit_rsp0, hit_rsp1, hit_bell, hit_istat;
   logic hit_imask, hit_ostat, hit_omask, hit_qreq, hit_qcpl;

   assign wr = h_sel & h_wr;
   assign rd = h_sel & ~h_wr;

   assign hit_cmd0  = (h_addr == ADDR_W'(OFF_CMD0));
   assign hit_cmd1  = (h_addr == ADDR_W'(OFF_CMD1));
   assign hit_rsp0  = (h_addr == ADDR_W'(OFF_RSP0));
   assign hit_rsp1  = (h_addr == ADDR_W'(OFF_RSP1));
   assign hit_bell  = (h_addr == ADDR_W'(OFF_BELL));
   assign hit_istat = (h_addr == ADDR_W'(OFF_ISTAT));
   assign hit_imask = (h_addr == ADDR_W'(OFF_IMASK));
   assign hit_ostat = (h_addr == ADDR_W'(OFF_OSTAT));
   assign hit_omask = (h_addr == ADDR_W'(OFF_OMASK));
   assign hit_qreq  = (h_addr == ADDR_W'(OFF_QREQ));
   assign hit_qcpl  = (h_addr == ADDR_W'(OFF_QCPL));

   // ---------------- queues ----------------
   logic          free_push, free_pop, free_empty, free_full, free_host;
   logic [DW-1:0] free_wdata, free_head;
   logic          post_push, post_empty, post_full;
   logic          cpl_push, cpl_pop, cpl_empty;
   logic [DW-1:0] cpl_head;

   assign free_host  = wr & hit_qcpl & ~free_full;
   assign l_free_rdy = ~free_full & ~(wr & hit_qcpl);
   assign free_push  = free_host | (l_free_push & l_free_rdy);
   assign free_wdata = free_host ? h_wdata : l_free_data;
   assign free_pop   = rd & hit_qreq & ~free_empty;
   assign post_push  = wr & hit_qreq & ~post_full;
   assign cpl_push   = l_cpl_push & ~l_cpl_full;
   assign cpl_pop    = rd & hit_qcpl & ~cpl_empty;

   qpmu_fifo #(.W(DW), .DEPTH(FREE_DEPTH)) u_free (
      .clk(clk), .rst_n(rst_n), .push(free_push), .wdata(free_wdata),
      .pop(free_pop), .rdata(free_head), .empty(free_empty), .full(free_full));

   qpmu_fifo #(.W(DW), .DEPTH(POST_DEPTH)) u_post (
      .clk(clk), .rst_n(rst_n), .push(post_push), .wdata(h_wdata),
      .pop(l_post_pop), .rdata(l_post_data), .empty(post_empty), .full(post_full));

   qpmu_fifo #(.W(DW), .DEPTH(CPL_DEPTH)) u_cpl (
      .clk(clk), .rst_n(rst_n), .push(cpl_push), .wdata(l_cpl_data),
      .pop(cpl_pop), .rdata(cpl_head), .empty(cpl_empty), .full(l_cpl_full));

   assign l_post_valid = ~post_empty;
   assign l_post_host  = l_post_data[DW-1];
   assign l_post_addr  = l_post_host ? {l_post_data[DW-2:0], {ALIGN_SH{1'b0}}}
                                     : HADDR_W'(l_post_data);

   // ---------------- message, doorbell, mask registers ----------------
   logic [DW-1:0]   rsp0, rsp1;
   logic [NSRC-1:0] imask, omask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_cmd0 <= '0;
         l_cmd1 <= '0;
         rsp0   <= '0;
         rsp1   <= '0;
         l_db   <= '0;
         imask  <= '0;
         omask  <= '0;
      end else begin
         if (wr && hit_cmd0)  l_cmd0 <= h_wdata;
         if (wr && hit_cmd1)  l_cmd1 <= h_wdata;
         if (l_rsp_we[0])     rsp0   <= l_rsp_data;
         if (l_rsp_we[1])     rsp1   <= l_rsp_data;
         if (wr && hit_imask) imask  <= h_wdata[NSRC-1:0];
         if (wr && hit_omask) omask  <= h_wdata[NSRC-1:0];
         l_db <= (l_db & ~l_db_clr) | ((wr && hit_bell) ? h_wdata : '0);
      end
   end

   // ---------------- status banks ----------------
   logic [NSRC-1:0] iset, oset, oclr, ostat;
   logic            cpl_evt;

   if (CPL_IRQ_LEVEL) begin : g_cpl_level
      assign cpl_evt = ~cpl_empty | cpl_push;
   end else begin : g_cpl_pulse
      assign cpl_evt = cpl_push;
   end

   always_comb begin
      iset = '0;
      iset[SRC_MSG0]  = wr & hit_cmd0;
      iset[SRC_MSG1]  = wr & hit_cmd1;
      iset[SRC_BELL]  = |l_db;
      iset[SRC_QUEUE] = post_push;
      oset = '0;
      oset[SRC_MSG0]  = l_rsp_we[0];
      oset[SRC_MSG1]  = l_rsp_we[1];
      oset[SRC_QUEUE] = cpl_evt;
      oclr = (wr && hit_ostat) ? h_wdata[NSRC-1:0] : '0;
   end

   qpmu_stat #(.N(NSRC)) u_istat (
      .clk(clk), .rst_n(rst_n), .set(iset), .clr(l_in_clr), .mask(imask),
      .status(l_istat), .irq(l_irq));

   qpmu_stat #(.N(NSRC)) u_ostat (
      .clk(clk), .rst_n(rst_n), .set(oset), .clr(oclr), .mask(omask),
      .status(ostat), .irq(h_irq));

   // ---------------- host read path ----------------
   logic [DW-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (hit_cmd0)       rd_mux = l_cmd0;
      else if (hit_cmd1)  rd_mux = l_cmd1;
      else if (hit_rsp0)  rd_mux = rsp0;
      else if (hit_rsp1)  rd_mux = rsp1;
      else if (hit_bell)  rd_mux = l_db;
      else if (hit_istat) rd_mux = DW'(l_istat);
      else if (hit_imask) rd_mux = DW'(imask);
      else if (hit_ostat) rd_mux = DW'(ostat);
      else if (hit_omask) rd_mux = DW'(omask);
      else if (hit_qreq)  rd_mux = free_empty ? EMPTY_MARK : free_head;
      else if (hit_qcpl)  rd_mux = cpl_empty ? EMPTY_MARK : cpl_head;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  h_rdata <= '0;
      else if (rd) h_rdata <= rd_mux;
   end

   // ---------------- assertions ----------------
   assert_cpl_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
      l_cpl_push |-> !l_cpl_full);
   assert_cpl_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      l_cpl_push |=> ostat[SRC_QUEUE]);
   assert_post_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      l_post_pop |-> l_post_valid);
   assert_empty_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit_qreq && free_empty) |=> (h_rdata == EMPTY_MARK));
   assert_bell_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_bell) |=> ((l_db & $past(h_wdata)) == $past(h_wdata)));
   assert_cmd_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_cmd0) |=> (l_cmd0 == $past(h_wdata)));
   assert_post_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_qreq && !post_full) |=> l_istat[SRC_QUEUE]);
endmodule

// File: tb/qpmu_top_bench.sv
module qpmu_top_bench;
   import qpmu_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                h_sel, h_wr;
   logic [7:0]          h_addr;
   logic [DW-1:0]       h_wdata, h_rdata;
   logic                h_irq;
   logic                l_free_push, l_free_rdy;
   logic [DW-1:0]       l_free_data;
   logic                l_post_pop, l_post_valid, l_post_host;
   logic [DW-1:0]       l_post_data;
   logic [HADDR_W-1:0]  l_post_addr;
   logic                l_cpl_push, l_cpl_full;
   logic [DW-1:0]       l_cpl_data, l_cmd0, l_cmd1, l_rsp_data, l_db, l_db_clr;
   logic [1:0]          l_rsp_we;
   logic [NSRC-1:0]     l_istat, l_in_clr;
   logic                l_irq;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qpmu_top u_qpmu_top (
      .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
      .l_free_push(l_free_push), .l_free_data(l_free_data), .l_free_rdy(l_free_rdy),
      .l_post_pop(l_post_pop), .l_post_valid(l_post_valid), .l_post_data(l_post_data),
      .l_post_host(l_post_host), .l_post_addr(l_post_addr),
      .l_cpl_push(l_cpl_push), .l_cpl_data(l_cpl_data), .l_cpl_full(l_cpl_full),
      .l_cmd0(l_cmd0), .l_cmd1(l_cmd1), .l_rsp_we(l_rsp_we), .l_rsp_data(l_rsp_data),
      .l_db(l_db), .l_db_clr(l_db_clr), .l_istat(l_istat), .l_in_clr(l_in_clr),
      .l_irq(l_irq));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = d;
      @(negedge clk);
      h_sel = 1'b0; h_wr = 1'b0;
   endtask

   task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      h_sel = 1'b1; h_wr = 1'b0; h_addr = a;
      @(negedge clk);
      h_sel = 1'b0;
      d = h_rdata;
   endtask

   task automatic rd_expect(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      host_rd(a, v);
      check(tag, 64'(v), 64'(exp));
   endtask

   task automatic loc_free(input logic [31:0] d);
      @(negedge clk); l_free_push = 1'b1; l_free_data = d;
      @(negedge clk); l_free_push = 1'b0;
   endtask

   task automatic loc_cpl(input logic [31:0] d);
      @(negedge clk); l_cpl_push = 1'b1; l_cpl_data = d;
      @(negedge clk); l_cpl_push = 1'b0;
   endtask

   task automatic loc_pop();
      @(negedge clk); l_post_pop = 1'b1;
      @(negedge clk); l_post_pop = 1'b0;
   endtask

   task automatic loc_in_clr(input logic [3:0] m);
      @(negedge clk); l_in_clr = m;
      @(negedge clk); l_in_clr = '0;
   endtask

   task automatic loc_db_clr(input logic [31:0] m);
      @(negedge clk); l_db_clr = m;
      @(negedge clk); l_db_clr = '0;
   endtask

   task automatic loc_rsp(input logic [1:0] we, input logic [31:0] d);
      @(negedge clk); l_rsp_we = we; l_rsp_data = d;
      @(negedge clk); l_rsp_we = '0;
   endtask

   task automatic t_reset();
      check("R1 h_rdata", 64'(h_rdata), 64'h0);
      check("R1 h_irq", 64'(h_irq), 64'h0);
      check("R1 l_irq", 64'(l_irq), 64'h0);
      check("R1 post_valid", 64'(l_post_valid), 64'h0);
      check("R1 istat", 64'(l_istat), 64'h0);
      check("R1 doorbell", 64'(l_db), 64'h0);
      check("R1 cpl_full", 64'(l_cpl_full), 64'h0);
      rd_expect("R1 imask", 8'h28, 32'h0);
      rd_expect("R1 omask", 8'h34, 32'h0);
   endtask

   task automatic t_empty();
      rd_expect("R3 empty req port", 8'h40, 32'hFFFF_FFFF);
      rd_expect("R3 empty cpl port", 8'h44, 32'hFFFF_FFFF);
      loc_free(32'h0000_0100);
      rd_expect("R3 cpl empty again", 8'h44, 32'hFFFF_FFFF);
      rd_expect("R3 free intact", 8'h40, 32'h0000_0100);
      rd_expect("R3 empty after drain", 8'h40, 32'hFFFF_FFFF);
   endtask

   task automatic t_free();
      loc_free(32'h0000_0100);
      loc_free(32'h0000_0200);
      loc_free(32'h0000_0300);
      rd_expect("R2 first", 8'h40, 32'h0000_0100);
      rd_expect("R2 second", 8'h40, 32'h0000_0200);
      rd_expect("R2 third", 8'h40, 32'h0000_0300);
      rd_expect("R2 drained", 8'h40, 32'hFFFF_FFFF);
   endtask

   task automatic t_post();
      host_wr(8'h40, 32'h0000_0300);
      host_wr(8'h40, 32'h8000_1234);
      check("R4 valid", 64'(l_post_valid), 64'h1);
      check("R4 head offset", 64'(l_post_data), 64'h300);
      check("R4 offset not host", 64'(l_post_host), 64'h0);
      check("R4 offset addr", 64'(l_post_addr), 64'h300);
      check("R4 istat q bit", 64'(l_istat), 64'h8);
      check("R9 l_irq from post", 64'(l_irq), 64'h1);
      loc_pop();
      check("R4 host word", 64'(l_post_data), 64'h8000_1234);
      check("R4 host flag", 64'(l_post_host), 64'h1);
      check("R4 host addr", 64'(l_post_addr), 64'h2_4680);
      loc_pop();
      check("R4 empty", 64'(l_post_valid), 64'h0);
      loc_in_clr(4'h8);
      check("R8 local clear", 64'(l_istat), 64'h0);
      check("R9 l_irq low", 64'(l_irq), 64'h0);
   endtask

   task automatic t_cpl();
      loc_cpl(32'hAAAA_0001);
      check("R9 h_irq on cpl", 64'(h_irq), 64'h1);
      loc_cpl(32'h0000_0055);
      rd_expect("R5 ostat", 8'h30, 32'h8);
      rd_expect("R5 cpl first", 8'h44, 32'hAAAA_0001);
      rd_expect("R5 cpl second", 8'h44, 32'h0000_0055);
      rd_expect("R5 cpl drained", 8'h44, 32'hFFFF_FFFF);
      host_wr(8'h30, 32'h7);
      rd_expect("R8 zero bits keep", 8'h30, 32'h8);
      host_wr(8'h30, 32'h8);
      rd_expect("R8 w1c", 8'h30, 32'h0);
      check("R9 h_irq cleared", 64'(h_irq), 64'h0);
   endtask

   task automatic t_mask();
      host_wr(8'h34, 32'h8);
      loc_cpl(32'h0000_0077);
      check("R9 masked h_irq", 64'(h_irq), 64'h0);
      rd_expect("R9 status still set", 8'h30, 32'h8);
      host_wr(8'h34, 32'h0);
      check("R9 unmasked h_irq", 64'(h_irq), 64'h1);
      host_wr(8'h30, 32'h8);
      rd_expect("R5 masked entry", 8'h44, 32'h0000_0077);
      check("R9 h_irq idle", 64'(h_irq), 64'h0);
   endtask

   task automatic t_return();
      @(negedge clk);
      h_sel = 1'b1; h_wr = 1'b1; h_addr = 8'h44; h_wdata = 32'h0000_0700;
      l_free_push = 1'b1; l_free_data = 32'h0000_0900;
      #1 check("R6 rdy low on host return", 64'(l_free_rdy), 64'h0);
      @(negedge clk);
      h_sel = 1'b0; h_wr = 1'b0;
      #1 check("R6 rdy back", 64'(l_free_rdy), 64'h1);
      @(negedge clk);
      l_free_push = 1'b0;
      rd_expect("R6 returned first", 8'h40, 32'h0000_0700);
      rd_expect("R6 local second", 8'h40, 32'h0000_0900);
      rd_expect("R6 drained", 8'h40, 32'hFFFF_FFFF);
   endtask

   task automatic t_msg();
      host_wr(8'h10, 32'h0000_C0DE);
      check("R7 cmd0", 64'(l_cmd0), 64'hC0DE);
      check("R7 istat bit0", 64'(l_istat), 64'h1);
      check("R9 l_irq on cmd", 64'(l_irq), 64'h1);
      host_wr(8'h14, 32'h0000_BEEF);
      check("R7 cmd1", 64'(l_cmd1), 64'hBEEF);
      check("R7 istat bits", 64'(l_istat), 64'h3);
      loc_rsp(2'b01, 32'h0000_C0DE);
      rd_expect("R7 rsp0", 8'h18, 32'h0000_C0DE);
      rd_expect("R7 ostat bit0", 8'h30, 32'h1);
      check("R9 h_irq on rsp", 64'(h_irq), 64'h1);
      loc_rsp(2'b10, 32'h0000_BEEF);
      rd_expect("R7 rsp1", 8'h1C, 32'h0000_BEEF);
      rd_expect("R7 ostat bits", 8'h30, 32'h3);
      host_wr(8'h30, 32'h3);
      loc_in_clr(4'hF);
      check("R8 istat cleared", 64'(l_istat), 64'h0);
   endtask

   task automatic t_bell();
      host_wr(8'h20, 32'h5);
      host_wr(8'h20, 32'h2);
      check("R10 doorbell or", 64'(l_db), 64'h7);
      check("R10 istat bell", 64'(l_istat), 64'h4);
      rd_expect("R10 host view", 8'h20, 32'h7);
      loc_db_clr(32'h3);
      check("R10 partial clear", 64'(l_db), 64'h4);
      host_wr(8'h28, 32'h4);
      check("R9 bell masked", 64'(l_irq), 64'h0);
      loc_db_clr(32'h4);
      check("R10 bell empty", 64'(l_db), 64'h0);
      loc_in_clr(4'h4);
      check("R10 status cleared", 64'(l_istat), 64'h0);
      host_wr(8'h28, 32'h0);
   endtask

   task automatic t_ro();
      host_wr(8'h18, 32'hDEAD_DEAD);
      rd_expect("R11 rsp0 kept", 8'h18, 32'h0000_C0DE);
      host_wr(8'h1C, 32'hDEAD_DEAD);
      rd_expect("R11 rsp1 kept", 8'h1C, 32'h0000_BEEF);
      host_wr(8'h10, 32'h1);
      host_wr(8'h24, 32'hF);
      check("R11 istat kept", 64'(l_istat), 64'h1);
      rd_expect("R11 istat read", 8'h24, 32'h1);
      host_wr(8'h3C, 32'h1234);
      rd_expect("R11 unmapped read", 8'h3C, 32'h0);
      rd_expect("R11 queue untouched", 8'h40, 32'hFFFF_FFFF);
      loc_in_clr(4'hF);
   endtask

   initial begin
      rst_n = 1'b0;
      h_sel = 1'b0; h_wr = 1'b0; h_addr = '0; h_wdata = '0;
      l_free_push = 1'b0; l_free_data = '0; l_post_pop = 1'b0;
      l_cpl_push = 1'b0; l_cpl_data = '0; l_rsp_we = '0; l_rsp_data = '0;
      l_db_clr = '0; l_in_clr = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_empty();
      t_free();
      t_post();
      t_cpl();
      t_mask();
      t_return();
      t_msg();
      t_bell();
      t_ro();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vectors++;
         misses++;
         $display("FAIL watchdog R1 actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule